// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block manages the RTS/CTS handshake for a UART bridge. On the receive side it compares the fill count of the receive FIFO against a fixed watermark of 450 bytes. It drives the active-low request-to-send output high once that level is reached, so the far end stops sending. It drives the output low again as soon as the count drops below the watermark.

On the transmit side it samples the active-low clear-to-send input through a two-flop synchronizer. It grants each new byte start that the transmitter requests. Once the far end raises clear-to-send, at most two more byte starts are granted. Returning the input low restores unlimited grants. A byte that is already in progress always finishes, and it is not charged against those two credits. When the flow-control enable is low, request-to-send stays low and clear-to-send has no effect.

Top module: `uart_flow_ctrl`

## Requirements
- R1: With flow control enabled and a receive fill count below 450, `rts_n` is low one clock after the count is presented.
- R2: With flow control enabled and a fill count of 450 or more, `rts_n` is high one clock after the count is presented.
- R3: `rts_n` returns low on the clock after the fill count falls back below 450, with no hysteresis band.
- R4: With flow control disabled, `rts_n` is held low whatever the fill count, and a high `cts_n` does not limit transmit grants.
- R5: With flow control enabled and `cts_n` low, a byte-start request made while no byte is in progress is granted by a one-cycle `tx_grant` pulse on the next clock.
- R6: After a high level on `cts_n` has passed the two-flop synchronizer, no more than two further grants are issued while it stays high.
- R7: Driving `cts_n` low again clears the credit count and restores unlimited grants.
- R8: A byte is in progress from its grant until the `tx_done` strobe. No new grant is issued during that time, and a byte granted before `cts_n` rose does not use one of the two credits.
- R9: Directly after reset, `rts_n` and `tx_grant` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_en | input | 1 | Hardware flow-control enable |
| rx_level | input | LVL_W (10) | Receive FIFO fill count |
| rts_n | output | 1 | Request to send, active low, registered |
| cts_n | input | 1 | Clear to send from far end, active low, asynchronous |
| tx_req | input | 1 | Transmitter asks to start a byte; held until granted |
| tx_grant | output | 1 | One-cycle permission to start the requested byte |
| tx_done | input | 1 | Strobe marking the end of the byte in progress |

## Verification
The receive path is driven with fill counts of 449, 450 and 511, then 449 again. This separates an off-by-one watermark compare from a missing return path and from a hysteresis band. The transmit path is driven with a run of requests under each of four conditions: `cts_n` low, `cts_n` high, `cts_n` high with flow control off, and `cts_n` low again. Counting the grants in each run separates the credit limit from the enable gating and from the restore on the falling edge. One run raises `cts_n` while a byte is still in progress. It checks that the request made during that byte waits for `tx_done`, and that the in-progress byte does not use up a credit.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  // Fixed handshake constants of the bridge.
  localparam int unsigned FC_WATERMARK = 450;
  localparam int unsigned FC_CREDITS   = 2;
  localparam int unsigned FC_SYNC      = 2;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fc_rx_gate.sv
module fc_rx_gate #(
  parameter int unsigned LVL_W     = 10,
  parameter int unsigned WATERMARK = 450
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fc_en,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rts_n
);
  localparam logic [LVL_W-1:0] WM = LVL_W'(WATERMARK);

  logic stop_now;
  assign stop_now = fc_en && (rx_level >= WM);

  always_ff @(posedge clk) begin
    if (rst) rts_n <= 1'b0;
    else     rts_n <= stop_now;
  end

  AST_RTS_STOP: assert property (@(posedge clk) disable iff (rst)
    (fc_en && rx_level >= WM) |=> rts_n); // R2
  AST_RTS_READY: assert property (@(posedge clk) disable iff (rst)
    (!fc_en || rx_level < WM) |=> !rts_n); // R3
endmodule

// File: rtl/fc_tx_credit.sv
module fc_tx_credit #(
  parameter int unsigned CREDITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fc_en,
  input  logic cts_hold,
  input  logic tx_req,
  input  logic tx_done,
  output logic tx_grant
);
  localparam int unsigned CW = $clog2(CREDITS + 1);
  localparam logic [CW-1:0] FULL = CW'(CREDITS);

  logic          busy;
  logic          throttled;
  logic [CW-1:0] credits;
  logic          allowed;
  logic          start;
  logic          hold_edge;

  assign allowed   = !throttled || (credits != '0);
  assign start     = tx_req && !busy && allowed;
  assign hold_edge = fc_en && cts_hold && !throttled;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tx_grant <= 1'b0;
    end else begin
      tx_grant <= start;
      if (start)        busy <= 1'b1;
      else if (tx_done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      throttled <= 1'b0;
      credits   <= '0;
    end else if (hold_edge) begin
      throttled <= 1'b1;
      credits   <= start ? FULL - 1'b1 : FULL;
    end else if (!fc_en || !cts_hold) begin
      throttled <= 1'b0;
      credits   <= '0;
    end else if (start) begin
      credits   <= credits - 1'b1;
    end
  end

  AST_NO_GRANT_DRY: assert property (@(posedge clk) disable iff (rst)
    (throttled && credits == '0) |=> !tx_grant); // R6
  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    credits <= FULL); // R6
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    busy |=> !tx_grant); // R8
  AST_OPEN_GRANT: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !busy && !throttled) |=> tx_grant); // R5
  AST_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (!cts_hold || !fc_en) |=> !throttled); // R7
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_fc_pkg::*;
#(
  parameter int unsigned LVL_W     = 10,
  parameter int unsigned WATERMARK = FC_WATERMARK,
  parameter int unsigned CREDITS   = FC_CREDITS,
  parameter int unsigned SYNC      = FC_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fc_en,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rts_n,
  input  logic             cts_n,
  input  logic             tx_req,
  output logic             tx_grant,
  input  logic             tx_done
);
  logic cts_hold;

  fc_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_cts_sync (
    .clk(clk), .rst(rst), .d(cts_n), .q(cts_hold)
  );

  fc_rx_gate #(.LVL_W(LVL_W), .WATERMARK(WATERMARK)) u_rx (
    .clk(clk), .rst(rst), .fc_en(fc_en), .rx_level(rx_level), .rts_n(rts_n)
  );

  fc_tx_credit #(.CREDITS(CREDITS)) u_tx (
    .clk(clk), .rst(rst), .fc_en(fc_en), .cts_hold(cts_hold),
    .tx_req(tx_req), .tx_done(tx_done), .tx_grant(tx_grant)
  );

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_grant |=> !tx_grant); // R8
endmodule

// File: tb/uart_flow_ctrl_bench.sv
module uart_flow_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fc_en = 1'b0;
  logic [9:0] rx_level = '0;
  logic       rts_n;
  logic       cts_n = 1'b0;
  logic       tx_req = 1'b0;
  logic       tx_grant;
  logic       tx_done = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_flow_ctrl u_uart_flow_ctrl (
    .clk(clk), .rst(rst), .fc_en(fc_en), .rx_level(rx_level), .rts_n(rts_n),
    .cts_n(cts_n), .tx_req(tx_req), .tx_grant(tx_grant), .tx_done(tx_done)
  );

  task automatic check(string req, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Request one byte; returns 1 if granted. Finishes the byte with tx_done.
  task automatic send_byte(output bit got);
    got = 1'b0;
    @(negedge clk); tx_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (tx_grant) begin got = 1'b1; break; end
    end
    @(negedge clk); tx_req = 1'b0;
    if (got) begin
      tick(1); tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
    end
  endtask

  task automatic count_bytes(int n, output int granted);
    bit g;
    granted = 0;
    for (int i = 0; i < n; i++) begin
      send_byte(g);
      if (g) granted++;
    end
  endtask

  task automatic set_level(int lvl, int exp_rts, string req);
    @(negedge clk); rx_level = 10'(lvl);
    @(posedge clk); #1;
    check(req, rts_n, exp_rts);
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    check("R9 rts_n", rts_n, 0);
    check("R9 tx_grant", tx_grant, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_rts;
    @(negedge clk); fc_en = 1'b1;
    set_level(449, 0, "R1 level 449");
    set_level(450, 1, "R2 level 450");
    set_level(511, 1, "R2 level 511");
    set_level(449, 0, "R3 back to 449");
    set_level(0, 0, "R1 level 0");
    @(negedge clk); fc_en = 1'b0;
    set_level(600, 0, "R4 disabled level 600");
    @(negedge clk); fc_en = 1'b1;
    set_level(600, 1, "R2 re-enabled 600");
    set_level(10, 0, "R3 level 10");
  endtask

  task automatic t_open;
    int n;
    cts_n = 1'b0; tick(4);
    count_bytes(5, n);
    check("R5 grants with cts low", n, 5);
  endtask

  task automatic t_throttle;
    int n;
    @(negedge clk); cts_n = 1'b1; tick(4);
    count_bytes(5, n);
    check("R6 grants after cts high", n, 2);
    @(negedge clk); cts_n = 1'b0; tick(4);
    count_bytes(4, n);
    check("R7 grants after cts low again", n, 4);
  endtask

  task automatic t_disabled;
    int n;
    @(negedge clk); fc_en = 1'b0; cts_n = 1'b1; tick(4);
    count_bytes(5, n);
    check("R4 cts ignored when disabled", n, 5);
    @(negedge clk); fc_en = 1'b1; tick(2);
    count_bytes(4, n);
    check("R6 enable while cts high", n, 2);
    @(negedge clk); cts_n = 1'b0; tick(4);
  endtask

  task automatic t_in_flight;
    int n;
    bit early;
    @(negedge clk); tx_req = 1'b1;
    @(posedge clk); #1;
    check("R5 grant next clock", tx_grant, 1);
    @(negedge clk); tx_req = 1'b0; cts_n = 1'b1;
    tick(4);
    tx_req = 1'b1;
    early = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      if (tx_grant) early = 1'b1;
    end
    check("R8 no grant while busy", early, 0);
    @(negedge clk); tx_req = 1'b0; tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    count_bytes(4, n);
    check("R8 in-flight byte uses no credit", n, 2);
    @(negedge clk); cts_n = 1'b0; tick(4);
  endtask

  initial begin
    t_reset();
    t_rts();
    t_open();
    t_throttle();
    t_disabled();
    t_in_flight();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule